// File: doc/BRIEF.md
# Interrupt Request Capture with Per-Line Edge/Level Select

This block turns a set of raw interrupt request wires into a register of pending requests that a downstream priority resolver can inspect. Each line is set to edge-sensitive or level-sensitive mode by a mode register that software writes as one word. A fixed per-instance mask is applied to every write, so lines that must stay edge-sensitive can never be switched. The raw inputs may be asynchronous. They pass through a two-flop synchroniser before any decision is made.

Each line is tracked by a small state machine of type `line_state_e`. The state encodes two bits: the pending bit (bit 1) and the last-seen-level history bit (bit 0). The four states are `LN_IDLE` (not pending, input last low), `LN_HELD` (not pending, input still high after its request was taken), `LN_PEND_LOW` (pending, input last low) and `LN_PEND_HIGH` (pending, input last high).

In level mode every line goes to `LN_PEND_HIGH` when the synchronised input is high and to `LN_IDLE` when it is low. In edge mode the transitions are as follows:
- rise-capture: `LN_IDLE` or `LN_PEND_LOW` to `LN_PEND_HIGH` on a high input.
- fall-forget: `LN_PEND_HIGH` to `LN_PEND_LOW`, or `LN_HELD` to `LN_IDLE`, on a low input.
- take-high: `LN_PEND_HIGH` to `LN_HELD` on an acknowledge while the input is high.
- take-low: `LN_PEND_LOW` or `LN_PEND_HIGH` to `LN_IDLE` on an acknowledge while the input is low.

All other combinations hold their state.

Top module: `irq_req_capture`

## Requirements
- R1: A change on `irq_in` reaches the capture logic through two synchroniser flops. A request first appears on `req_pending` after the third rising clock edge that follows the input change, and not after the second.
- R2: For a line whose `mode_rdata` bit is 1 (level mode), the `req_pending` bit is 1 while the synchronised input is high and 0 while it is low.
- R3: For a line whose `mode_rdata` bit is 0 (edge mode), a high input sets the `req_pending` bit only when the previously sampled level was low. An input that stays high does not raise the request again after it has been acknowledged.
- R4: In edge mode, a low input clears only the history bit. A pending request stays set.
- R5: An acknowledge (`ack_valid` high with `ack_line` = n) clears `req_pending[n]` on the next edge when line n is in edge mode.
- R6: An acknowledge has no effect on a line in level mode. Its request stays set while the input is high.
- R7: A cycle with `mode_wr` high stores `mode_wdata & MODE_MASK`, and `mode_rdata` shows it after that edge. Bits that are 0 in `MODE_MASK` (by default lines 0 to 2, mask 8'hF8) always read 0 and stay edge mode. With `mode_wr` low, `mode_rdata` holds its value.
- R8: An active-low reset clears `req_pending`, the history and the synchroniser. It sets `mode_rdata` to 0, which puts every line in edge mode.
- R9: In edge mode, when an acknowledge and a new rising edge on the same line fall on the same clock edge, the new edge wins and the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw request wires, may be asynchronous |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | NUM_LINES | Mode word, 1 = level, 0 = edge per line |
| mode_rdata | output | NUM_LINES | Stored mode word |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_line | input | LINE_W | Index of the acknowledged line |
| req_pending | output | NUM_LINES | Pending request bits to the priority resolver |

## Verification
A line state machine stuck in the wrong state shows up on `req_pending` at the next acknowledge or input change. A missed history bit makes a held-high edge line reappear as pending within three cycles of its acknowledge. A lost pending bit makes a dropped edge request vanish one edge after the input falls. A mode register that ignores the mask or holds stale data is visible on `mode_rdata` one edge after the write. It also changes how the next acknowledge on that line behaves. The same-edge collision of an acknowledge and a fresh edge is forced cycle-exactly, so a wrong priority between the two clears the request at once.

// File: rtl/irq_req_capture_pkg.sv
package irq_req_capture_pkg;

    // bit 1: request pending, bit 0: last sampled input level
    typedef enum logic [1:0] {
        LN_IDLE      = 2'b00,
        LN_HELD      = 2'b01,
        LN_PEND_LOW  = 2'b10,
        LN_PEND_HIGH = 2'b11
    } line_state_e;

endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/irq_mode_reg.sv
module irq_mode_reg #(
    parameter int                 WIDTH     = 8,
    parameter logic [WIDTH-1:0]   WRITE_MSK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mode
);

    logic [WIDTH-1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr) begin
            mode_q <= wdata & WRITE_MSK;
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_req_capture_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic level_mode,
    input  logic ack,
    output logic pending
);

    line_state_e cur_q;
    line_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= LN_IDLE;
        end else begin
            cur_q <= nxt;
        end
    end

    always_comb begin
        nxt = cur_q;
        if (level_mode) begin
            nxt = lvl ? LN_PEND_HIGH : LN_IDLE;
        end else begin
            unique case (cur_q)
                LN_IDLE:      nxt = lvl ? LN_PEND_HIGH : LN_IDLE;
                LN_HELD:      nxt = lvl ? LN_HELD : LN_IDLE;
                // a fresh edge beats a same-cycle acknowledge
                LN_PEND_LOW:  nxt = lvl ? LN_PEND_HIGH
                                        : (ack ? LN_IDLE : LN_PEND_LOW);
                LN_PEND_HIGH: nxt = lvl ? (ack ? LN_HELD : LN_PEND_HIGH)
                                        : (ack ? LN_IDLE : LN_PEND_LOW);
                default:      nxt = LN_IDLE;
            endcase
        end
    end

    always_comb begin
        pending = (cur_q == LN_PEND_LOW) || (cur_q == LN_PEND_HIGH);
    end

endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int                     NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0]   MODE_MASK = NUM_LINES'(8'hF8),
    localparam int                    LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 mode_wr,
    input  logic [NUM_LINES-1:0] mode_wdata,
    output logic [NUM_LINES-1:0] mode_rdata,
    input  logic                 ack_valid,
    input  logic [LINE_W-1:0]    ack_line,
    output logic [NUM_LINES-1:0] req_pending
);

    logic [NUM_LINES-1:0] lvl_sync;
    logic [NUM_LINES-1:0] mode_bits;

    irq_req_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (lvl_sync)
    );

    irq_mode_reg #(.WIDTH(NUM_LINES), .WRITE_MSK(MODE_MASK)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mode_wr),
        .wdata (mode_wdata),
        .mode  (mode_bits)
    );

    assign mode_rdata = mode_bits;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic ack_hit;
        assign ack_hit = ack_valid && (ack_line == LINE_W'(g));

        irq_line_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl        (lvl_sync[g]),
            .level_mode (mode_bits[g]),
            .ack        (ack_hit),
            .pending    (req_pending[g])
        );
    end

endmodule

// File: rtl/irq_req_capture_chk.sv
module irq_req_capture_chk #(
    parameter int                   NUM_LINES = 8,
    parameter logic [NUM_LINES-1:0] MODE_MASK = NUM_LINES'(8'hF8),
    parameter int                   LINE_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] lvl_sync,
    input logic                 mode_wr,
    input logic [NUM_LINES-1:0] mode_wdata,
    input logic [NUM_LINES-1:0] mode_rdata,
    input logic                 ack_valid,
    input logic [LINE_W-1:0]    ack_line,
    input logic [NUM_LINES-1:0] req_pending
);

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (req_pending == '0 && mode_rdata == '0));

    p_mode_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> mode_rdata == ($past(mode_wdata) & MODE_MASK));

    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_rdata));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        p_level_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_rdata[i] && lvl_sync[i]) |=> req_pending[i]);

        p_level_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_rdata[i] && !lvl_sync[i]) |=> !req_pending[i]);

        // new edge captured even against a same-cycle acknowledge (R9)
        p_edge_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_rdata[i] && lvl_sync[i] && !$past(lvl_sync[i])) |=> req_pending[i]);

        p_edge_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_rdata[i] && req_pending[i] && !(ack_valid && ack_line == LINE_W'(i)))
                |=> req_pending[i]);

        p_edge_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_rdata[i] && ack_valid && ack_line == LINE_W'(i) && !lvl_sync[i])
                |=> !req_pending[i]);
    end

endmodule

bind irq_req_capture irq_req_capture_chk #(
    .NUM_LINES (NUM_LINES),
    .MODE_MASK (MODE_MASK),
    .LINE_W    (LINE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl_sync    (lvl_sync),
    .mode_wr     (mode_wr),
    .mode_wdata  (mode_wdata),
    .mode_rdata  (mode_rdata),
    .ack_valid   (ack_valid),
    .ack_line    (ack_line),
    .req_pending (req_pending)
);

// File: tb/irq_req_capture_bench.sv
`timescale 1ns/1ps
module irq_req_capture_bench;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic         mode_wr = 1'b0;
    logic [N-1:0] mode_wdata = '0;
    logic [N-1:0] mode_rdata;
    logic         ack_valid = 1'b0;
    logic [2:0]   ack_line = '0;
    logic [N-1:0] req_pending;

    always #2 clk = ~clk;

    irq_req_capture u_irq_req_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .mode_wr     (mode_wr),
        .mode_wdata  (mode_wdata),
        .mode_rdata  (mode_rdata),
        .ack_valid   (ack_valid),
        .ack_line    (ack_line),
        .req_pending (req_pending)
    );

    typedef struct {
        bit           is_mode;
        logic [N-1:0] exp;
        string        tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic [N-1:0] act;
                it  = q.pop_front();
                act = it.is_mode ? mode_rdata : req_pending;
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: %s actual=%02h expected=%02h", it.tag,
                             it.is_mode ? "mode_rdata" : "req_pending", act, it.exp);
                end
            end
        end
    end

    task automatic push_req(input logic [N-1:0] e, input string tag);
        item_t it;
        it.is_mode = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic push_mode(input logic [N-1:0] e, input string tag);
        item_t it;
        it.is_mode = 1'b1; it.exp = e; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(input logic [N-1:0] v);
        mode_wr = 1'b1; mode_wdata = v;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic do_ack(input int line);
        ack_valid = 1'b1; ack_line = 3'(line);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        push_req(8'h00, "R8 reset pending");
        push_mode(8'h00, "R8 reset mode");

        tick(1); write_mode(8'hFF);
        push_mode(8'hF8, "R7 write masked");
        tick(1); write_mode(8'h34);
        push_mode(8'h30, "R7 masked line 2 dropped");
        tick(3);
        push_mode(8'h30, "R7 hold without write");

        // edge line 0
        irq_in[0] = 1'b1;
        tick(2); push_req(8'h00, "R1 not yet after two edges");
        tick(1); push_req(8'h01, "R1 R3 visible after third edge");
        tick(4); push_req(8'h01, "R3 held while high");
        do_ack(0); push_req(8'h00, "R5 ack clears edge line");
        tick(4); push_req(8'h00, "R3 no retrigger while high");
        irq_in[0] = 1'b0;
        tick(3); push_req(8'h00, "R4 low after ack stays clear");
        irq_in[0] = 1'b1;
        tick(3); push_req(8'h01, "R3 new rising edge");
        irq_in[0] = 1'b0;
        tick(3); push_req(8'h01, "R4 low keeps request");
        do_ack(0); push_req(8'h00, "R5 ack clears while low");

        // level line 4
        irq_in[4] = 1'b1;
        tick(3); push_req(8'h10, "R2 level high pending");
        do_ack(4); push_req(8'h10, "R6 ack ignored in level");
        tick(2); push_req(8'h10, "R6 still pending");
        irq_in[4] = 1'b0;
        tick(3); push_req(8'h00, "R2 level low clears");

        // masked line 2 stays edge
        irq_in[2] = 1'b1;
        tick(3); push_req(8'h04, "R3 line 2 captured");
        do_ack(2); push_req(8'h00, "R7 masked line acts as edge");
        irq_in[2] = 1'b0;
        tick(3);

        // same-edge collision on line 1
        irq_in[1] = 1'b1;
        tick(3); push_req(8'h02, "R3 line 1 captured");
        irq_in[1] = 1'b0;
        tick(3); push_req(8'h02, "R4 line 1 pending low");
        irq_in[1] = 1'b1;
        tick(2);
        do_ack(1); push_req(8'h02, "R9 new edge beats ack");
        do_ack(1); push_req(8'h00, "R5 second ack clears");
        irq_in[1] = 1'b0;
        tick(3);

        // mixed lines
        irq_in = 8'h21;
        tick(3); push_req(8'h21, "R2 R3 mixed capture");
        irq_in = 8'h00;
        tick(3); push_req(8'h01, "R2 R4 level drops edge stays");
        do_ack(0); push_req(8'h00, "R5 mixed ack");

        // reset returns all lines to edge mode
        rst_n = 1'b0;
        tick(1);
        rst_n = 1'b1;
        push_mode(8'h00, "R8 mode cleared by reset");
        push_req(8'h00, "R8 pending cleared by reset");
        irq_in[4] = 1'b1;
        tick(3); push_req(8'h10, "R8 line 4 captured");
        do_ack(4); push_req(8'h00, "R8 line 4 now edge");
        irq_in = '0;

        tick(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule